// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block decides, every cycle, where the two ALU operands of a five-stage in-order pipeline come from. It also decides whether the front of the pipeline must pause for one cycle. For each operand of the instruction sitting in the decode-to-execute register, it compares the source register number against the destinations of the two older instructions that are still in flight. When the value the operand needs has already been computed but not yet written back, the block points the operand mux at the newer of the two pipeline results instead of the register file.

A result that comes out of a data-memory read is not ready early enough for the instruction right behind it. In that case the block raises a hold that freezes the program counter and the fetch-to-decode register. In the same cycle it raises a bubble that zeroes the control bits written into the decode-to-execute register, so the slot becomes a nop. The hold lasts exactly one cycle. On the following cycle the loaded value is one stage further on, and the ordinary bypass from the memory-to-writeback register delivers it.

Top module: `hz_ctrl`

## Requirements
- R1: Each operand select is 2 bits: 2'b00 means register file, 2'b10 means the execute-to-memory result, 2'b01 means the memory-to-writeback result. The value 2'b11 never appears. With no matching producer the select is 2'b00.
- R2: An operand selects 2'b10 when the execute-to-memory write flag is set and that stage's destination equals the operand's source register.
- R3: An operand selects 2'b01 when the memory-to-writeback write flag is set, its destination equals the source register, and R2 does not apply.
- R4: When both older stages match the same source, the execute-to-memory result (2'b10) wins.
- R5: Register 0 never produces a bypass match or a load-use match.
- R6: Operand A is steered by the execute-stage rs field and operand B by the rt field, independently of each other.
- R7: The hold is raised when the decode-to-execute instruction reads memory and its nonzero destination equals either the rs or the rt field of the fetch-to-decode instruction. It is not raised otherwise.
- R8: The bubble is high in exactly the cycles in which the hold is high.
- R9: The hold never lasts more than one consecutive cycle, even if the load-use inputs stay unchanged.
- R10: After the one-cycle hold has let the load advance, the dependent instruction's operand selects the memory-to-writeback result (2'b01).
- R11: Under reset with all inputs zero, both selects are 2'b00 and hold and bubble are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifid_rs_i | input | REG_ADDR_W | rs field of the instruction in fetch-to-decode |
| ifid_rt_i | input | REG_ADDR_W | rt field of the instruction in fetch-to-decode |
| idex_rs_i | input | REG_ADDR_W | rs field in decode-to-execute (operand A source) |
| idex_rt_i | input | REG_ADDR_W | rt field in decode-to-execute (operand B source) |
| idex_rd_i | input | REG_ADDR_W | Destination of the decode-to-execute instruction |
| idex_memread_i | input | 1 | Decode-to-execute instruction reads data memory |
| exmem_rd_i | input | REG_ADDR_W | Destination held in execute-to-memory |
| exmem_regwrite_i | input | 1 | Execute-to-memory instruction writes a register |
| memwb_rd_i | input | REG_ADDR_W | Destination held in memory-to-writeback |
| memwb_regwrite_i | input | 1 | Memory-to-writeback instruction writes a register |
| fwd_a_o | output | 2 | Operand A source select |
| fwd_b_o | output | 2 | Operand B source select |
| stall_o | output | 1 | Freeze the PC and the fetch-to-decode register |
| bubble_o | output | 1 | Zero the control bits entering decode-to-execute |

## Verification
A load-use hold and an execute-to-memory bypass can occur in the same cycle. This happens when the load itself needs a base register that the instruction ahead of it has just computed. The bench provokes this with a short pipeline sequence: an add producing r2, then a load using r2 as its base and writing r1, then an instruction reading r1. In the hold cycle it expects hold, bubble and operand A = 2'b10 together. It then advances the modelled pipeline by one cycle with a nop in place and checks that the hold has dropped. One cycle later it checks that the dependent operand selects 2'b01. The selects and the hold are also swept over every input combination of a 2-bit register address, with expected values computed directly from the matching rules.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_sel_e;

    localparam int unsigned FWD_SEL_W = 2;

    // Newer producer first: an instruction in execute-to-memory is younger
    // than one in memory-to-writeback.
    function automatic fwd_sel_e pick_fwd(input logic ex_hit, input logic mw_hit);
        if (ex_hit) return FWD_EXMEM;
        if (mw_hit) return FWD_MEMWB;
        return FWD_RF;
    endfunction

endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] src_i,
    input  logic [REG_ADDR_W-1:0] exmem_rd_i,
    input  logic                  exmem_we_i,
    input  logic [REG_ADDR_W-1:0] memwb_rd_i,
    input  logic                  memwb_we_i,
    output logic [1:0]            sel_o
);
    import hz_pkg::*;

    logic     src_live;
    logic     ex_hit;
    logic     mw_hit;
    fwd_sel_e sel;

    always_comb begin
        src_live = (src_i != '0);
        ex_hit   = src_live && exmem_we_i && (exmem_rd_i == src_i);
        mw_hit   = src_live && memwb_we_i && (memwb_rd_i == src_i);
        sel      = pick_fwd(ex_hit, mw_hit);
        sel_o    = sel;
    end

    a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
        sel_o != 2'b11);

    a_r5_zero_src_uses_rf: assert property (@(posedge clk) disable iff (rst)
        (src_i == '0) |-> (sel_o == 2'b00));

    a_r4_exmem_wins: assert property (@(posedge clk) disable iff (rst)
        (exmem_we_i && memwb_we_i && exmem_rd_i == src_i && memwb_rd_i == src_i && src_i != '0)
        |-> (sel_o == 2'b10));

endmodule

// File: rtl/hz_load_guard.sv
module hz_load_guard #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_i,
    input  logic [REG_ADDR_W-1:0] ld_rd_i,
    input  logic [REG_ADDR_W-1:0] use_rs_i,
    input  logic [REG_ADDR_W-1:0] use_rt_i,
    output logic                  stall_o
);
    logic hazard;
    logic stall_q;

    always_comb begin
        hazard  = ld_i && (ld_rd_i != '0) &&
                  ((ld_rd_i == use_rs_i) || (ld_rd_i == use_rt_i));
        stall_o = hazard && !stall_q;
    end

    always_ff @(posedge clk) begin
        if (rst) stall_q <= 1'b0;
        else     stall_q <= stall_o;
    end

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);

    a_r7_needs_live_load: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (ld_i && ld_rd_i != '0));

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] ifid_rs_i,
    input  logic [REG_ADDR_W-1:0] ifid_rt_i,
    input  logic [REG_ADDR_W-1:0] idex_rs_i,
    input  logic [REG_ADDR_W-1:0] idex_rt_i,
    input  logic [REG_ADDR_W-1:0] idex_rd_i,
    input  logic                  idex_memread_i,
    input  logic [REG_ADDR_W-1:0] exmem_rd_i,
    input  logic                  exmem_regwrite_i,
    input  logic [REG_ADDR_W-1:0] memwb_rd_i,
    input  logic                  memwb_regwrite_i,
    output logic [1:0]            fwd_a_o,
    output logic [1:0]            fwd_b_o,
    output logic                  stall_o,
    output logic                  bubble_o
);
    import hz_pkg::*;

    localparam int unsigned NUM_OPS = 2;

    logic [REG_ADDR_W-1:0] op_src [NUM_OPS];
    logic [FWD_SEL_W-1:0]  op_sel [NUM_OPS];
    logic                  hold;

    assign op_src[0] = idex_rs_i;
    assign op_src[1] = idex_rt_i;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_fwd_sel #(.REG_ADDR_W(REG_ADDR_W)) u_sel (
            .clk        (clk),
            .rst        (rst),
            .src_i      (op_src[g]),
            .exmem_rd_i (exmem_rd_i),
            .exmem_we_i (exmem_regwrite_i),
            .memwb_rd_i (memwb_rd_i),
            .memwb_we_i (memwb_regwrite_i),
            .sel_o      (op_sel[g])
        );
    end

    hz_load_guard #(.REG_ADDR_W(REG_ADDR_W)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .ld_i     (idex_memread_i),
        .ld_rd_i  (idex_rd_i),
        .use_rs_i (ifid_rs_i),
        .use_rt_i (ifid_rt_i),
        .stall_o  (hold)
    );

    assign fwd_a_o  = op_sel[0];
    assign fwd_b_o  = op_sel[1];
    assign stall_o  = hold;
    assign bubble_o = hold;

    a_r8_bubble_follows_stall: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> bubble_o);

endmodule

// File: tb/hz_ctrl_tb_top.sv
module hz_ctrl_tb_top;
    localparam int unsigned AW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd, exmem_rd, memwb_rd;
    logic          idex_memread, exmem_we, memwb_we;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall, bubble;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    hz_ctrl #(.REG_ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .ifid_rs_i(ifid_rs), .ifid_rt_i(ifid_rt),
        .idex_rs_i(idex_rs), .idex_rt_i(idex_rt), .idex_rd_i(idex_rd),
        .idex_memread_i(idex_memread),
        .exmem_rd_i(exmem_rd), .exmem_regwrite_i(exmem_we),
        .memwb_rd_i(memwb_rd), .memwb_regwrite_i(memwb_we),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .bubble_o(bubble)
    );

    function automatic logic [1:0] exp_sel(logic [AW-1:0] src, logic exw, logic [AW-1:0] exrd,
                                           logic mww, logic [AW-1:0] mwrd);
        if (src != 0 && exw && exrd == src) return 2'b10;
        if (src != 0 && mww && mwrd == src) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic zero_inputs();
        ifid_rs = 0; ifid_rt = 0; idex_rs = 0; idex_rt = 0; idex_rd = 0;
        idex_memread = 0; exmem_rd = 0; exmem_we = 0; memwb_rd = 0; memwb_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        zero_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 fwd_a", {2'b0, fwd_a}, 4'h0);
        chk("R11 fwd_b", {2'b0, fwd_b}, 4'h0);
        chk("R11 stall/bubble", {2'b0, stall, bubble}, 4'h0);
        @(negedge clk);
        rst = 1'b0;

        // Bypass sweep: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < 1024; v++) begin
            @(negedge clk);
            {idex_rs, idex_rt, exmem_rd, exmem_we, memwb_rd, memwb_we} = v[9:0];
            #1;
            chk("R2/R3/R4/R5 operand A", {2'b0, fwd_a},
                {2'b0, exp_sel(idex_rs, exmem_we, exmem_rd, memwb_we, memwb_rd)});
            chk("R6/R1 operand B", {2'b0, fwd_b},
                {2'b0, exp_sel(idex_rt, exmem_we, exmem_rd, memwb_we, memwb_rd)});
        end
        @(negedge clk);
        zero_inputs();

        // Load-use sweep: R7 R8 R9 R5
        for (int v = 0; v < 128; v++) begin
            logic es;
            @(negedge clk);
            {ifid_rs, ifid_rt, idex_rd, idex_memread} = v[6:0];
            es = idex_memread && idex_rd != 0 && (idex_rd == ifid_rs || idex_rd == ifid_rt);
            #1;
            chk("R7/R5 hold", {3'b0, stall}, {3'b0, es});
            chk("R8 bubble", {3'b0, bubble}, {3'b0, es});
            @(negedge clk);
            #1;
            if (es) chk("R9 hold released", {3'b0, stall, bubble}, 4'h0);
            @(negedge clk);
            idex_memread = 0;
        end
        @(negedge clk);
        zero_inputs();
        @(negedge clk);

        // Pipeline sequence: add r2 ; lw r1,(r2) ; and r3,r1,r3
        idex_rs = 2; idex_rt = 0; idex_rd = 1; idex_memread = 1;
        exmem_rd = 2; exmem_we = 1;
        ifid_rs = 1; ifid_rt = 3;
        #1;
        chk("R7 hold on load-use", {3'b0, stall}, 4'h1);
        chk("R8 bubble on load-use", {3'b0, bubble}, 4'h1);
        chk("R2 load base bypass during hold", {2'b0, fwd_a}, 4'h2);
        @(negedge clk);
        memwb_rd = 2; memwb_we = 1;
        exmem_rd = 1; exmem_we = 1;
        idex_rs = 0; idex_rt = 0; idex_rd = 0; idex_memread = 0;
        #1;
        chk("R9 hold after nop", {2'b0, stall, bubble}, 4'h0);
        @(negedge clk);
        memwb_rd = 1; memwb_we = 1;
        exmem_rd = 0; exmem_we = 0;
        idex_rs = 1; idex_rt = 3; idex_rd = 3;
        ifid_rs = 0; ifid_rt = 0;
        #1;
        chk("R10 loaded value via memwb", {2'b0, fwd_a}, 4'h1);
        chk("R10 other operand from rf", {2'b0, fwd_b}, 4'h0);
        chk("R10 no hold", {3'b0, stall}, 4'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule